// File: doc/BRIEF.md
# Smart Card Character Engine

This block moves single characters across one open-drain smart card I/O line, in one direction at a time. On transmit it turns a byte into a frame: a low start bit, eight data bits and an even parity bit, each one elementary time unit (etu) long, followed by a guard period with the line released. On receive it finds the falling edge of a start bit, confirms the start bit half an etu later, samples each later bit near the middle of its etu, and returns the restored byte together with a parity verdict.

Configuration inputs select the bit order and the data inversion. Inversion acts on the data bits only; the parity bit is always computed over the levels that appear on the line. Setting both gives inverse convention and clearing both gives direct convention. A protocol select chooses T=0 or T=1. In T=0 a parity failure is signalled back to the transmitting side by pulling the line low just after the parity bit, and the transmitter watches for that pulse. The guard period is normally two etu plus an extension count. A last-character input forces it to exactly two etu. A wait timer measures etu since the leading edge of the most recent character and raises a sticky error when a limit passes. Its clear input holds the timer and the flag at zero.

Top module: `sc_char_engine`

## Requirements
- R1: After reset, tx_busy, tx_done, tx_retry, rx_valid, wait_err and line_drive_low are all 0. With every configuration input at 0 the engine runs T=0, least significant bit first, with no inversion, a guard taken from cfg_guard_ext, and wait detection enabled.
- R2: When tx_start is high and the engine is idle, the transmitted frame begins on the next cycle. The start bit is low, then come eight data bits and then the parity bit, each lasting cfg_etu_div cycles. line_drive_low is 1 exactly while a transmitted bit is 0. Transmit and receive are never active together.
- R3: With cfg_msb_first at 0, data bit 0 is sent first and the first received data bit becomes bit 0. With cfg_msb_first at 1, data bit 7 is sent first and the first received data bit becomes bit 7.
- R4: With cfg_invert at 1, every data bit is inverted on the line, and received data bits are inverted before rx_data is formed. The parity bit is never inverted: it makes the count of 1 levels among the nine line bits (eight data bits and parity) even.
- R5: tx_busy stays high for (10 + G) * cfg_etu_div cycles. G is 2 + cfg_guard_ext when cfg_last_char is 0, and exactly 2 when cfg_last_char is 1, whatever cfg_guard_ext holds. tx_done pulses for one cycle as tx_busy falls.
- R6: A received frame gives a one-cycle rx_valid pulse, about 9.5 etu after the start edge. With it come the restored byte on rx_data and rx_parity_err set if the nine line bits do not have even parity.
- R7: A low level on the line shorter than half an etu is not taken as a start bit and produces no rx_valid.
- R8: In T=0, after a receive parity error, line_drive_low is held high from about 10.5 to 11.5 etu after the start edge. In T=1 no such pulse is driven.
- R9: In T=0 the transmitter samples the line 10.5 etu after the start of its frame. If the line is low there, tx_retry is set and stays set until the next transmission starts. In T=1 tx_retry stays 0.
- R10: wait_err becomes 1 once cfg_wait_limit etu have passed since the leading edge of the last character (transmit start or receive start edge) with no new leading edge. It then stays 1.
- R11: While cfg_wait_clr is 1, wait_err is 0 one cycle later and remains 0 whatever the line does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_t1 | input | 1 | 0: T=0, 1: T=1 |
| cfg_msb_first | input | 1 | 1: most significant data bit first |
| cfg_invert | input | 1 | 1: data bits inverted on the line |
| cfg_last_char | input | 1 | 1: guard forced to 2 etu |
| cfg_wait_clr | input | 1 | 1: wait timer held cleared, no detection |
| cfg_etu_div | input | 16 | Clock cycles per etu (at least 4) |
| cfg_guard_ext | input | 8 | Extra guard etu beyond 2 |
| cfg_wait_limit | input | 16 | Wait limit in etu |
| tx_start | input | 1 | Request to send tx_data |
| tx_data | input | 8 | Byte to send |
| tx_busy | output | 1 | Transmit frame and guard in progress |
| tx_done | output | 1 | One-cycle pulse at the end of the guard |
| tx_retry | output | 1 | Error pulse seen in T=0 |
| rx_valid | output | 1 | One-cycle pulse with a received byte |
| rx_data | output | 8 | Restored received byte |
| rx_parity_err | output | 1 | Parity failure of the last received byte |
| wait_err | output | 1 | Sticky wait-time error |
| line_in | input | 1 | Level of the I/O line |
| line_drive_low | output | 1 | 1 pulls the I/O line low |

## Verification
A transmitted bit k occupies cycles k*div to (k+1)*div-1 after the accepting edge, so the bench samples line_drive_low at the falling clock edge half an etu into each bit. It counts tx_busy at falling edges to get the exact guard length. Received results arrive about 9.5 etu after the start edge, plus two synchronizer cycles. The bench captures rx_valid at every falling edge and checks the captured byte only after the whole frame has been driven. The T=0 error pulse is checked at 11.25 etu, and its end is checked at 12.5 etu. wait_err is checked 10 cycles before and 10 cycles after limit*div cycles from the accepting edge, which is the cycle where it is due.

// File: rtl/sc_char_pkg.sv
package sc_char_pkg;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_SIGNAL} rx_state_e;

  // Line order: element i is the level of the i-th data bit on the wire.
  // The mapping is its own inverse, so the receiver uses it to restore data.
  function automatic logic [7:0] sc_map(input logic [7:0] v, input logic msb, input logic inv);
    logic [7:0] o;
    for (int i = 0; i < 8; i++) o[i] = (msb ? v[7-i] : v[i]) ^ inv;
    return o;
  endfunction

  function automatic logic sc_even_par(input logic [7:0] v);
    return ^v;
  endfunction

endpackage

// File: rtl/sc_char_tx.sv
module sc_char_tx
  import sc_char_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int GEXT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              t1,
  input  logic              msb_first,
  input  logic              invert,
  input  logic              last_char,
  input  logic [DIV_W-1:0]  div,
  input  logic [GEXT_W-1:0] gext,
  input  logic [7:0]        data,
  input  logic              line_s,
  output logic              busy,
  output logic              drive_low,
  output logic              done,
  output logic              retry,
  output logic              lead_evt
);
  localparam int IDX_W     = GEXT_W + 2;
  localparam int FRAME_ETU = 10;

  function automatic logic [IDX_W-1:0] guard_etu(input logic last, input logic [GEXT_W-1:0] ext);
    return last ? IDX_W'(2) : IDX_W'(ext) + IDX_W'(2);
  endfunction

  logic [9:0]       frm;
  logic [IDX_W-1:0] idx, last_idx;
  logic [DIV_W-1:0] cnt;
  logic             etu_end, retry_smp, frame_bit;
  logic [7:0]       line_bits;

  assign lead_evt  = start && !busy;
  assign etu_end   = (cnt == div - DIV_W'(1));
  assign retry_smp = busy && !t1 && (idx == IDX_W'(FRAME_ETU)) && (cnt == (div >> 1));
  assign frame_bit = (idx < IDX_W'(FRAME_ETU)) ? frm[idx[3:0]] : 1'b1;
  assign drive_low = busy && !frame_bit;
  assign line_bits = sc_map(data, msb_first, invert);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      retry    <= 1'b0;
      cnt      <= '0;
      idx      <= '0;
      last_idx <= '0;
      frm      <= '1;
    end else begin
      done <= 1'b0;
      if (lead_evt) begin
        busy     <= 1'b1;
        cnt      <= '0;
        idx      <= '0;
        retry    <= 1'b0;
        frm      <= {sc_even_par(line_bits), line_bits, 1'b0};
        last_idx <= IDX_W'(FRAME_ETU) + guard_etu(last_char, gext) - IDX_W'(1);
      end else if (busy) begin
        if (etu_end) begin
          cnt <= '0;
          if (idx == last_idx) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
        if (retry_smp && !line_s) retry <= 1'b1;
      end
    end
  end

  p_start_bit_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> drive_low);
  p_retry_t0_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry) |-> $past(!t1 && !line_s));
  p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
  import sc_char_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             t1,
  input  logic             msb_first,
  input  logic             invert,
  input  logic [DIV_W-1:0] div,
  input  logic             line_s,
  output logic             busy,
  output logic             valid,
  output logic [7:0]       data,
  output logic             par_err,
  output logic             err_drive,
  output logic             lead_evt
);
  localparam int CNT_W = DIV_W + 1;

  rx_state_e        st;
  logic [CNT_W-1:0] cnt, div_x, half_x;
  logic [3:0]       idx;
  logic [7:0]       sh;
  logic             line_q, bit_smp, start_chk, bad_par;

  assign div_x     = {1'b0, div};
  assign half_x    = {2'b0, div[DIV_W-1:1]};
  assign lead_evt  = enable && (st == RX_IDLE) && line_q && !line_s;
  assign start_chk = (st == RX_START) && (cnt == half_x);
  assign bit_smp   = (st == RX_BITS) && (cnt == div_x - CNT_W'(1));
  assign bad_par   = sc_even_par(sh) ^ line_s;
  assign busy      = (st != RX_IDLE);
  assign err_drive = (st == RX_SIGNAL) && (cnt >= div_x);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RX_IDLE;
      cnt     <= '0;
      idx     <= '0;
      sh      <= '0;
      line_q  <= 1'b1;
      valid   <= 1'b0;
      data    <= '0;
      par_err <= 1'b0;
    end else begin
      line_q <= line_s;
      valid  <= 1'b0;
      unique case (st)
        RX_IDLE: if (lead_evt) begin st <= RX_START; cnt <= '0; end
        RX_START: begin
          if (start_chk) begin
            cnt <= '0;
            idx <= '0;
            st  <= line_s ? RX_IDLE : RX_BITS;
          end else cnt <= cnt + CNT_W'(1);
        end
        RX_BITS: begin
          if (bit_smp) begin
            cnt <= '0;
            if (idx == 4'd8) begin
              valid   <= 1'b1;
              data    <= sc_map(sh, msb_first, invert);
              par_err <= bad_par;
              st      <= (bad_par && !t1) ? RX_SIGNAL : RX_IDLE;
            end else begin
              sh[idx[2:0]] <= line_s;
              idx          <= idx + 4'd1;
            end
          end else cnt <= cnt + CNT_W'(1);
        end
        RX_SIGNAL: begin
          if (cnt == (div_x << 1) - CNT_W'(1)) begin
            cnt <= '0;
            st  <= RX_IDLE;
          end else cnt <= cnt + CNT_W'(1);
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  p_errsig_after_bad_par_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_drive) |-> par_err);
  p_reject_glitch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_chk && line_s) |=> (st == RX_IDLE && !valid));

endmodule

// File: rtl/sc_char_wait.sv
module sc_char_wait #(
  parameter int DIV_W = 16,
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             lead,
  input  logic [DIV_W-1:0] div,
  input  logic [LIM_W-1:0] limit,
  output logic             wait_err
);
  logic             armed, etu_tick;
  logic [DIV_W-1:0] pre;
  logic [LIM_W-1:0] cnt;

  assign etu_tick = armed && (pre == div - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; pre <= '0; cnt <= '0; wait_err <= 1'b0;
    end else if (clr) begin
      armed <= 1'b0; pre <= '0; cnt <= '0; wait_err <= 1'b0;
    end else if (lead) begin
      armed <= 1'b1; pre <= '0; cnt <= '0;
    end else if (armed && !wait_err) begin
      if (etu_tick) begin
        pre <= '0;
        cnt <= cnt + LIM_W'(1);
        if (cnt == limit - LIM_W'(1)) wait_err <= 1'b1;
      end else pre <= pre + DIV_W'(1);
    end
  end

  p_clr_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !wait_err);
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_err && !clr) |=> wait_err);

endmodule

// File: rtl/sc_char_engine.sv
module sc_char_engine #(
  parameter int DIV_W  = 16,
  parameter int GEXT_W = 8,
  parameter int LIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_t1,
  input  logic              cfg_msb_first,
  input  logic              cfg_invert,
  input  logic              cfg_last_char,
  input  logic              cfg_wait_clr,
  input  logic [DIV_W-1:0]  cfg_etu_div,
  input  logic [GEXT_W-1:0] cfg_guard_ext,
  input  logic [LIM_W-1:0]  cfg_wait_limit,
  input  logic              tx_start,
  input  logic [7:0]        tx_data,
  output logic              tx_busy,
  output logic              tx_done,
  output logic              tx_retry,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  output logic              rx_parity_err,
  output logic              wait_err,
  input  logic              line_in,
  output logic              line_drive_low
);
  logic [1:0] sync_q;
  logic       line_s, rx_busy, tx_drive, rx_drive, tx_lead, rx_lead, tx_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], line_in};
  end
  assign line_s = sync_q[1];
  assign tx_go  = tx_start && !rx_busy;

  sc_char_tx #(.DIV_W(DIV_W), .GEXT_W(GEXT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_go), .t1(cfg_t1),
    .msb_first(cfg_msb_first), .invert(cfg_invert), .last_char(cfg_last_char),
    .div(cfg_etu_div), .gext(cfg_guard_ext), .data(tx_data), .line_s(line_s),
    .busy(tx_busy), .drive_low(tx_drive), .done(tx_done), .retry(tx_retry),
    .lead_evt(tx_lead)
  );

  sc_char_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .enable(!tx_busy), .t1(cfg_t1),
    .msb_first(cfg_msb_first), .invert(cfg_invert), .div(cfg_etu_div),
    .line_s(line_s), .busy(rx_busy), .valid(rx_valid), .data(rx_data),
    .par_err(rx_parity_err), .err_drive(rx_drive), .lead_evt(rx_lead)
  );

  sc_char_wait #(.DIV_W(DIV_W), .LIM_W(LIM_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wait_clr), .lead(tx_lead || rx_lead),
    .div(cfg_etu_div), .limit(cfg_wait_limit), .wait_err(wait_err)
  );

  assign line_drive_low = tx_drive || rx_drive;

  p_half_duplex_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_busy && rx_busy));

endmodule

// File: tb/sc_char_engine_tb_top.sv
module sc_char_engine_tb_top;
  localparam int DIV = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_t1 = 0, cfg_msb_first = 0, cfg_invert = 0, cfg_last_char = 0, cfg_wait_clr = 0;
  logic [15:0] cfg_etu_div = 16'(DIV);
  logic [7:0]  cfg_guard_ext = 8'd3;
  logic [15:0] cfg_wait_limit = 16'd20;
  logic tx_start = 0;
  logic [7:0] tx_data = '0;
  logic tx_busy, tx_done, tx_retry, rx_valid, rx_parity_err, wait_err, line_drive_low;
  logic [7:0] rx_data;
  logic tb_low = 0;
  wire  line_in = !(tb_low || line_drive_low);

  int n_chk = 0, n_bad = 0, busy_cyc = 0, cap_n = 0;
  logic [7:0] cap_d = '0;
  logic cap_e = 0;

  always #2 clk = ~clk;

  sc_char_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_t1(cfg_t1), .cfg_msb_first(cfg_msb_first),
    .cfg_invert(cfg_invert), .cfg_last_char(cfg_last_char), .cfg_wait_clr(cfg_wait_clr),
    .cfg_etu_div(cfg_etu_div), .cfg_guard_ext(cfg_guard_ext), .cfg_wait_limit(cfg_wait_limit),
    .tx_start(tx_start), .tx_data(tx_data), .tx_busy(tx_busy), .tx_done(tx_done),
    .tx_retry(tx_retry), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_parity_err(rx_parity_err), .wait_err(wait_err), .line_in(line_in),
    .line_drive_low(line_drive_low)
  );

  always @(negedge clk) begin
    if (tx_busy) busy_cyc++;
    if (rx_valid) begin cap_n++; cap_d = rx_data; cap_e = rx_parity_err; end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {msb_first, invert, byte, expected line levels: [7:0] data in send order, [8] parity}
  localparam logic [18:0] VEC [4] = '{
    {1'b0, 1'b0, 8'hA5, 9'h0A5},
    {1'b1, 1'b0, 8'h3B, 9'h1DC},
    {1'b1, 1'b1, 8'h3B, 9'h123},
    {1'b0, 1'b1, 8'h01, 9'h1FE}
  };

  task automatic send(input logic [7:0] d);
    @(negedge clk); busy_cyc = 0; tx_start = 1; tx_data = d;
    @(negedge clk); tx_start = 0;
  endtask

  task automatic tx_frame(input logic [7:0] d, input logic [8:0] lv, input string req);
    send(d);
    repeat (DIV/2) @(negedge clk);
    chk(line_drive_low == 1'b1, "R2 start bit", line_drive_low, 1);
    for (int k = 0; k < 9; k++) begin
      repeat (DIV) @(negedge clk);
      chk(line_drive_low == !lv[k], req, line_drive_low, !lv[k]);
    end
    while (tx_busy) @(negedge clk);
  endtask

  task automatic rx_frame(input logic [8:0] lv);
    @(negedge clk); tb_low = 1;
    repeat (DIV) @(negedge clk);
    for (int k = 0; k < 9; k++) begin
      tb_low = !lv[k];
      repeat (DIV) @(negedge clk);
    end
    tb_low = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n0, exp_busy;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!tx_busy && !tx_done && !tx_retry, "R1 tx idle", tx_busy, 0);
    chk(!rx_valid && !line_drive_low, "R1 rx idle", line_drive_low, 0);
    chk(!wait_err, "R1 wait_err", wait_err, 0);
    cfg_wait_clr = 1;

    // Vector table: transmit then receive, R2 R3 R4 R5 R6
    for (int v = 0; v < 4; v++) begin
      cfg_msb_first = VEC[v][18];
      cfg_invert    = VEC[v][17];
      tx_frame(VEC[v][16:9], VEC[v][8:0], "R3 R4 tx line level");
      exp_busy = (10 + 2 + int'(cfg_guard_ext)) * DIV;
      chk(busy_cyc == exp_busy, "R5 guard from extension", busy_cyc, exp_busy);
      chk(!tx_retry, "R9 no error pulse", tx_retry, 0);
      n0 = cap_n;
      rx_frame(VEC[v][8:0]);
      repeat (4*DIV) @(negedge clk);
      chk(cap_n == n0 + 1, "R6 one rx_valid", cap_n - n0, 1);
      chk(cap_d == VEC[v][16:9], "R3 R4 R6 rx data", cap_d, VEC[v][16:9]);
      chk(!cap_e, "R6 good parity", cap_e, 0);
    end
    cfg_msb_first = 0; cfg_invert = 0;

    // R5 last character forces 2 etu
    cfg_last_char = 1; cfg_guard_ext = 8'd7;
    tx_frame(8'hA5, 9'h0A5, "R2 tx line level");
    chk(busy_cyc == 12*DIV, "R5 last char guard", busy_cyc, 12*DIV);
    cfg_last_char = 0; cfg_guard_ext = 8'd3;

    // R7 glitch rejected
    n0 = cap_n;
    @(negedge clk); tb_low = 1;
    repeat (2) @(negedge clk); tb_low = 0;
    repeat (12*DIV) @(negedge clk);
    chk(cap_n == n0, "R7 glitch ignored", cap_n - n0, 0);

    // R8 T=0 parity error signal
    n0 = cap_n;
    rx_frame(9'h1A5);
    repeat (10) @(negedge clk);
    chk(line_drive_low == 1'b1, "R8 error pulse in T0", line_drive_low, 1);
    chk(cap_e == 1'b1, "R6 parity error flag", cap_e, 1);
    repeat (10) @(negedge clk);
    chk(line_drive_low == 1'b0, "R8 error pulse ends", line_drive_low, 0);
    // R8 T=1 no pulse
    cfg_t1 = 1;
    repeat (4*DIV) @(negedge clk);
    rx_frame(9'h1A5);
    repeat (10) @(negedge clk);
    chk(line_drive_low == 1'b0, "R8 no pulse in T1", line_drive_low, 0);
    chk(cap_e == 1'b1 && cap_n == n0 + 2, "R6 T1 parity error", cap_n - n0, 2);
    repeat (4*DIV) @(negedge clk);

    // R9 retransmit flag
    for (int p = 0; p < 2; p++) begin
      cfg_t1 = (p == 1);
      send(8'h5A);
      repeat (10*DIV - 1) @(negedge clk); tb_low = 1;
      repeat (DIV) @(negedge clk); tb_low = 0;
      while (tx_busy) @(negedge clk);
      chk(tx_retry == (p == 0), "R9 retry flag", tx_retry, (p == 0));
    end
    cfg_t1 = 0;

    // R10 wait error, R11 clear
    cfg_wait_clr = 0;
    @(negedge clk);
    send(8'h11);
    repeat (20*DIV - 11) @(negedge clk);
    chk(!wait_err, "R10 before limit", wait_err, 0);
    repeat (20) @(negedge clk);
    chk(wait_err, "R10 at limit", wait_err, 1);
    repeat (100) @(negedge clk);
    chk(wait_err, "R10 sticky", wait_err, 1);
    cfg_wait_clr = 1;
    @(negedge clk);
    chk(!wait_err, "R11 clear", wait_err, 0);
    send(8'h22);
    repeat (40*DIV) @(negedge clk);
    chk(!wait_err, "R11 detection off", wait_err, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule